// File: doc/BRIEF.md
# Serial-Bus Master Interrupt Status and Vector Unit

This unit holds the event status of a serial-bus master peripheral, along with the interrupt enables and the two DMA request enables. It drives one level-sensitive interrupt and two DMA request lines. The transfer engine reports events by pulsing bits of `evt_set`. It withdraws the two ready conditions through `evt_clr`, because software cannot clear those two bits.

Software uses a 16-bit register port with separate read and write addresses, so a read and a write can happen in the same cycle. Read data is registered and appears one cycle after the read strobe. The port decodes each address into one of five selections: `SEL_NONE`, `SEL_IE`, `SEL_STAT`, `SEL_VEC` and `SEL_DMA`, at word addresses (none), 0, 1, 2 and 3. Reading the vector selection returns the lowest pending enabled event, numbered from one, and clears that event. This lets a handler service events one at a time without a separate acknowledge write. The bus-busy input is not stored. It is merged into status reads only.

Top module: `sbm_irq_unit`

## Requirements
- R1: A synchronous reset clears the status, the interrupt enables and both DMA enables. After reset, `irq`, `dreq_rx` and `dreq_tx` are low and every register reads 0.
- R2: `irq` is high exactly when some stored status bit is set whose enable bit is also set. It follows the stored state with no extra cycle.
- R3: A read at address 1 returns the stored status on `rdata` one cycle after the strobe. `bus_busy` is ORed into bit 12. Only bits 0 to 5, 10, 11 and 15 are ever stored (mask 0x8C3F), so event pulses on any other bit are dropped. The bits are: 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 10 transmit underflow, 11 receive overrun, 15 single-byte data.
- R4: A read at address 2 finds the lowest bit index i set in both the status and the enables, returns i+1, and clears status bit i. When no enabled bit is pending, it returns 0 and changes nothing.
- R5: A write at address 1 clears each status bit where a 1 is written, but only bits 0, 1, 2 and 5. The receive-ready and transmit-ready bits (3 and 4) and all other bits are unaffected.
- R6: `evt_clr` clears the matching status bits. If a bit is set and cleared in the same cycle, the set wins.
- R7: A write at address 0 stores the interrupt enables. Only the low 6 bits are kept, or the low 5 when the `LEGACY_IE` parameter is 1. Enable bit i gates status bit i.
- R8: A write at address 3 stores only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). Writing 1 to bit 15 clears interrupt enable 3. Writing 1 to bit 7 clears interrupt enable 4.
- R9: `dreq_rx` equals receive DMA enable AND status bit 3. `dreq_tx` equals transmit DMA enable AND status bit 4.
- R10: When a vector read and a write fall in the same cycle, the vector is chosen from the status and enables held before that cycle, and its clear is applied before the write takes effect.
- R11: Reads at unmapped addresses return 0. Writes at unmapped addresses, and at the vector address, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, valid the cycle after `rd_en` |
| bus_busy | input | 1 | Bus-busy level, shown in status bit 12 |
| evt_set | input | 16 | Event set pulses from the transfer engine |
| evt_clr | input | 16 | Hardware clear pulses from the transfer engine |
| irq | output | 1 | Level interrupt |
| dreq_rx | output | 1 | Receive DMA request |
| dreq_tx | output | 1 | Transmit DMA request |

## Verification
The vector path is driven with several pending patterns:
- Two enabled bits at once, which shows that the lowest index wins and is cleared first.
- A lower pending bit that is disabled, which shows that the enables gate the selection.
- No enabled bit pending, which separates the zero return from index 0.

Same-cycle pairings check the merge order:
- A vector read against a status write, and against an enable write, show that the selection uses pre-write values.
- Set against clear on one bit shows that the set wins.

Writing all ones to status and to DMA control shows which bits the write masks protect.

// File: rtl/sbm_irq_pkg.sv
package sbm_irq_pkg;

    localparam int DATA_W = 16;

    // Status bit positions (software visible)
    localparam int BIT_NACK  = 1;
    localparam int BIT_ARDY  = 2;
    localparam int BIT_RXRDY = 3;
    localparam int BIT_TXRDY = 4;
    localparam int BIT_BUSY  = 12;

    // DMA control bit positions
    localparam int BIT_DMA_RX = 15;
    localparam int BIT_DMA_TX = 7;

    // Bits that can be held in the status register
    localparam logic [DATA_W-1:0] STORE_MASK  = 16'h8C3F;
    // Bits software may clear by writing one
    localparam logic [DATA_W-1:0] SW_CLR_MASK = 16'h0027;

    // Word addresses
    localparam int ADR_IE   = 0;
    localparam int ADR_STAT = 1;
    localparam int ADR_VEC  = 2;
    localparam int ADR_DMA  = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IE,
        SEL_STAT,
        SEL_VEC,
        SEL_DMA
    } reg_sel_e;

endpackage

// File: rtl/sbm_irq_lowbit.sv
module sbm_irq_lowbit #(
    parameter int W = 16,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     onehot
);
    logic [W:0] below;

    assign below[0] = 1'b0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign below[i+1] = below[i] | vec[i];
            assign onehot[i]  = vec[i] & ~below[i];
        end
    endgenerate

    assign found = below[W];

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/sbm_irq_status.sv
module sbm_irq_status #(
    parameter int              W           = 16,
    parameter logic [W-1:0]    STORE_MASK  = '1,
    parameter logic [W-1:0]    SW_CLR_MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt_set,
    input  logic [W-1:0] evt_clr,
    input  logic         sw_clr_en,
    input  logic [W-1:0] sw_clr_bits,
    input  logic         vec_clr_en,
    input  logic [W-1:0] vec_clr_bit,
    output logic [W-1:0] stat_q
);
    logic [W-1:0] stat_d;

    // Order: vector clear, software clear, hardware clear, then set wins.
    always_comb begin
        stat_d = stat_q;
        if (vec_clr_en) stat_d = stat_d & ~vec_clr_bit;
        if (sw_clr_en)  stat_d = stat_d & ~(sw_clr_bits & SW_CLR_MASK);
        stat_d = stat_d & ~evt_clr;
        stat_d = (stat_d | evt_set) & STORE_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end
endmodule

// File: rtl/sbm_irq_ctrl.sv
module sbm_irq_ctrl #(
    parameter int W      = 16,
    parameter int IE_W   = 6,
    parameter int RX_BIT = 15,
    parameter int TX_BIT = 7,
    parameter int RX_IE  = 3,
    parameter int TX_IE  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ie_we,
    input  logic            dma_we,
    input  logic [W-1:0]    wdata,
    output logic [IE_W-1:0] ie_q,
    output logic            dma_rx_q,
    output logic            dma_tx_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q     <= '0;
            dma_rx_q <= 1'b0;
            dma_tx_q <= 1'b0;
        end else if (ie_we) begin
            ie_q <= wdata[IE_W-1:0];
        end else if (dma_we) begin
            dma_rx_q <= wdata[RX_BIT];
            dma_tx_q <= wdata[TX_BIT];
            if (wdata[RX_BIT]) ie_q[RX_IE] <= 1'b0;
            if (wdata[TX_BIT]) ie_q[TX_IE] <= 1'b0;
        end
    end
endmodule

// File: rtl/sbm_irq_unit.sv
module sbm_irq_unit #(
    parameter int ADDR_W    = 3,
    parameter bit LEGACY_IE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    input  logic              bus_busy,
    input  logic [15:0]       evt_set,
    input  logic [15:0]       evt_clr,
    output logic              irq,
    output logic              dreq_rx,
    output logic              dreq_tx
);
    import sbm_irq_pkg::*;

    localparam int W     = DATA_W;
    localparam int IE_W  = LEGACY_IE ? 5 : 6;
    localparam int IDX_W = $clog2(W);

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (int'(a))
            ADR_IE:   s = SEL_IE;
            ADR_STAT: s = SEL_STAT;
            ADR_VEC:  s = SEL_VEC;
            ADR_DMA:  s = SEL_DMA;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    reg_sel_e rsel, wsel;
    logic rd_vec, rd_stat, wr_stat, wr_ie, wr_dma;

    assign rsel    = decode(rd_addr);
    assign wsel    = decode(wr_addr);
    assign rd_vec  = rd_en && (rsel == SEL_VEC);
    assign rd_stat = rd_en && (rsel == SEL_STAT);
    assign wr_stat = wr_en && (wsel == SEL_STAT);
    assign wr_ie   = wr_en && (wsel == SEL_IE);
    assign wr_dma  = wr_en && (wsel == SEL_DMA);

    logic [W-1:0]    stat_q;
    logic [IE_W-1:0] ie_q;
    logic [W-1:0]    ie_ext;
    logic            dma_rx_q, dma_tx_q;
    logic [W-1:0]    pend;
    logic            pend_any;
    logic [IDX_W-1:0] pend_idx;
    logic [W-1:0]    pend_bit;

    assign ie_ext = W'(ie_q);
    assign pend   = stat_q & ie_ext;

    sbm_irq_lowbit #(.W(W)) u_lowbit (
        .vec    (pend),
        .found  (pend_any),
        .idx    (pend_idx),
        .onehot (pend_bit)
    );

    sbm_irq_status #(
        .W           (W),
        .STORE_MASK  (STORE_MASK),
        .SW_CLR_MASK (SW_CLR_MASK)
    ) u_status (
        .clk         (clk),
        .rst         (rst),
        .evt_set     (evt_set),
        .evt_clr     (evt_clr),
        .sw_clr_en   (wr_stat),
        .sw_clr_bits (wdata),
        .vec_clr_en  (rd_vec),
        .vec_clr_bit (pend_bit),
        .stat_q      (stat_q)
    );

    sbm_irq_ctrl #(
        .W      (W),
        .IE_W   (IE_W),
        .RX_BIT (BIT_DMA_RX),
        .TX_BIT (BIT_DMA_TX),
        .RX_IE  (BIT_RXRDY),
        .TX_IE  (BIT_TXRDY)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ie_we    (wr_ie),
        .dma_we   (wr_dma),
        .wdata    (wdata),
        .ie_q     (ie_q),
        .dma_rx_q (dma_rx_q),
        .dma_tx_q (dma_tx_q)
    );

    // Read data register: one-cycle latency
    logic [W-1:0] rd_d;

    always_comb begin
        rd_d = '0;
        unique case (rsel)
            SEL_IE:   rd_d = ie_ext;
            SEL_STAT: rd_d = stat_q | (W'(bus_busy) << BIT_BUSY);
            SEL_VEC:  rd_d = pend_any ? (W'(pend_idx) + W'(1)) : '0;
            SEL_DMA:  rd_d = (W'(dma_rx_q) << BIT_DMA_RX) | (W'(dma_tx_q) << BIT_DMA_TX);
            SEL_NONE: rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_d;
    end

    assign irq     = pend_any;
    assign dreq_rx = dma_rx_q & stat_q[BIT_RXRDY];
    assign dreq_tx = dma_tx_q & stat_q[BIT_TXRDY];
endmodule

// File: rtl/sbm_irq_checker.sv
module sbm_irq_checker (
    input logic        clk,
    input logic        rst,
    input logic        rd_vec,
    input logic        rd_stat,
    input logic        wr_stat,
    input logic        wr_dma,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic        bus_busy,
    input logic [15:0] evt_set,
    input logic [15:0] evt_clr,
    input logic [15:0] stat_q,
    input logic [15:0] ie_ext
);
    logic [15:0] pend_c;
    assign pend_c = stat_q & ie_ext;

    a_r3_busy_bit: assert property (@(posedge clk) disable iff (rst)
        rd_stat && bus_busy |=> rdata[12]);

    a_r4_vec_hit: assert property (@(posedge clk) disable iff (rst)
        rd_vec && (pend_c != 16'h0) |=> (rdata != 16'h0) && (rdata <= 16'd16));

    a_r4_vec_miss: assert property (@(posedge clk) disable iff (rst)
        rd_vec && (pend_c == 16'h0) |=> rdata == 16'h0);

    a_r4_vec_clears_one: assert property (@(posedge clk) disable iff (rst)
        rd_vec && (pend_c != 16'h0) && (evt_set == 16'h0) && (evt_clr == 16'h0) && !wr_stat
        |=> $countones(stat_q) == $countones($past(stat_q)) - 1);

    a_r5_ready_kept: assert property (@(posedge clk) disable iff (rst)
        wr_stat && !rd_vec && (evt_clr[4:3] == 2'b00)
        |=> (stat_q[4:3] & $past(stat_q[4:3])) == $past(stat_q[4:3]));

    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        evt_set[1] |=> stat_q[1]);

    a_r8_dma_forces_ie: assert property (@(posedge clk) disable iff (rst)
        wr_dma && wdata[15] |=> !ie_ext[3]);
endmodule

bind sbm_irq_unit sbm_irq_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_vec   (rd_vec),
    .rd_stat  (rd_stat),
    .wr_stat  (wr_stat),
    .wr_dma   (wr_dma),
    .wdata    (wdata),
    .rdata    (rdata),
    .bus_busy (bus_busy),
    .evt_set  (evt_set),
    .evt_clr  (evt_clr),
    .stat_q   (stat_q),
    .ie_ext   (ie_ext)
);

// File: tb/sbm_irq_unit_test.sv
module sbm_irq_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        bus_busy = 1'b0;
    logic [15:0] evt_set = '0;
    logic [15:0] evt_clr = '0;
    logic        irq, dreq_rx, dreq_tx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        took = 1'b0;

    always #5 clk = ~clk;

    sbm_irq_unit uut (
        .clk(clk), .rst(rst),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
        .rdata(rdata), .bus_busy(bus_busy),
        .evt_set(evt_set), .evt_clr(evt_clr),
        .irq(irq), .dreq_rx(dreq_rx), .dreq_tx(dreq_tx)
    );

    // Monitor: compares read data one cycle after each read strobe
    always @(posedge clk) took <= rd_en;

    always @(negedge clk) begin
        if (took) begin
            logic [15:0] e;
            string t;
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL %s: unexpected read data %h", "scoreboard", rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    bad++;
                    $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
                end
            end
        end
    end

    task automatic rd(input int a, input logic [15:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 3'(a);
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] s, input logic [15:0] c);
        @(negedge clk);
        evt_set = s; evt_clr = c;
        @(negedge clk);
        evt_set = '0; evt_clr = '0;
    endtask

    task automatic chk(input logic act, input logic e, input string t);
        total++;
        if (act !== e) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", t, act, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(irq, 1'b0, "R1 irq");
        chk(dreq_rx, 1'b0, "R1 dreq_rx");
        chk(dreq_tx, 1'b0, "R1 dreq_tx");
        rd(1, 16'h0000, "R1 status");
        rd(0, 16'h0000, "R1 enables");
        rd(3, 16'h0000, "R1 dma");

        // R7: enable width
        wr(0, 16'hFFFF);
        rd(0, 16'h003F, "R7 enable mask");

        // R2 / R3
        pulse(16'h0002, 16'h0000);
        chk(irq, 1'b1, "R2 irq on enabled event");
        rd(1, 16'h0002, "R3 status read");
        bus_busy = 1'b1;
        rd(1, 16'h1002, "R3 busy merged");
        bus_busy = 1'b0;
        pulse(16'h5000, 16'h0000);
        rd(1, 16'h0002, "R3 unstored bits dropped");

        // R4: vector ordering
        pulse(16'h0024, 16'h0000);
        rd(2, 16'h0002, "R4 vector bit1");
        rd(2, 16'h0003, "R4 vector bit2");
        rd(2, 16'h0006, "R4 vector bit5");
        rd(2, 16'h0000, "R4 vector empty");
        chk(irq, 1'b0, "R4 irq after drain");

        // R4 / R2: disabled lower bit skipped
        wr(0, 16'h0010);
        pulse(16'h0012, 16'h0000);
        rd(2, 16'h0005, "R4 vector masked");
        rd(1, 16'h0002, "R4 disabled bit kept");
        chk(irq, 1'b0, "R2 irq masked");

        // R5: software clear mask
        pulse(16'h8C3F, 16'h0000);
        wr(1, 16'hFFFF);
        rd(1, 16'h8C18, "R5 write-one-to-clear");

        // R6: hardware clear and set priority
        pulse(16'h0000, 16'h0018);
        rd(1, 16'h8C00, "R6 hardware clear");
        pulse(16'h0008, 16'h0008);
        rd(1, 16'h8C08, "R6 set wins");

        // R8 / R9
        wr(0, 16'h003F);
        wr(3, 16'hFFFF);
        rd(3, 16'h8080, "R8 dma stored bits");
        rd(0, 16'h0027, "R8 enables forced off");
        chk(dreq_rx, 1'b1, "R9 dreq_rx");
        chk(dreq_tx, 1'b0, "R9 dreq_tx idle");
        pulse(16'h0010, 16'h0000);
        chk(dreq_tx, 1'b1, "R9 dreq_tx");
        wr(3, 16'h0000);
        chk(dreq_rx, 1'b0, "R9 dreq_rx off");
        chk(dreq_tx, 1'b0, "R9 dreq_tx off");
        rd(0, 16'h0027, "R8 enables unchanged");

        // R10: same-cycle vector read and writes
        pulse(16'h0000, 16'hFFFF);
        pulse(16'h0005, 16'h0000);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 3'd2;
        wr_en = 1'b1; wr_addr = 3'd1; wdata = 16'h0001;
        exp_q.push_back(16'h0001); tag_q.push_back("R10 vector with status write");
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        rd(1, 16'h0004, "R10 status after merge");
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 3'd2;
        wr_en = 1'b1; wr_addr = 3'd0; wdata = 16'h0000;
        exp_q.push_back(16'h0003); tag_q.push_back("R10 vector uses old enables");
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        rd(1, 16'h0000, "R10 status cleared");
        rd(0, 16'h0000, "R10 enables written");

        // R11: unmapped and vector-address writes
        wr(5, 16'hFFFF);
        wr(2, 16'hFFFF);
        rd(5, 16'h0000, "R11 unmapped read");
        rd(0, 16'h0000, "R11 enables untouched");
        rd(3, 16'h0000, "R11 dma untouched");

        @(negedge clk);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule